// File: doc/BRIEF.md
# Command-Queue SPI Master

This block is an SPI master that is fed by a queue of 32-bit command words rather than by plain data bytes. Each command carries one frame of transmit data along with its own framing controls. These controls are the chip-select lines to drive, whether chip select is held into the next frame, which of four stored attribute sets applies, whether the frame ends the queue, and whether the transfer counter restarts. Received frames land in a small receive FIFO and are read back right-aligned in the low half of a 32-bit word.

Software-side access is reduced to strobes:
- a command push;
- a receive pop;
- writes to the control, attribute, status and interrupt-enable registers.

Serial timing is paced by an external `tick` input. Each tick is one SCK half-period. One tick also serves as the delay from chip-select assertion to the first SCK edge, and one tick as the delay from the last SCK edge to chip-select release.

A frame marked as the end of the queue sets a sticky flag and halts the queue. Clearing that flag (write 1) lets the remaining commands run. An interrupt output follows the flag gated by its enable.

Top module: `cq_spi_master`

## Requirements
- R1: After reset, every chip-select line is 0 (inactive level 0), `sck` is 0, `irq` is 0, the status word and `frame_count` are 0, and the engine is disabled.
- R2: A frame is N = F+1 bits long. F is bits 30:27 of the attribute set chosen by command bits 29:28. The received word holds the frame right-aligned in bits 15:0, with upper bits 0. Frame sizes of 4, 8 and 16 bits behave alike.
- R3: Attribute bit 24 selects the bit order. When it is 0, `mosi` sends the N low data bits most-significant first. When it is 1, they are sent least-significant first.
- R4: Attribute bit 26 (CPOL) sets the `sck` idle level, and bit 25 (CPHA) selects sampling on the trailing edge instead of the leading edge. `sck` rests at the CPOL of the last frame.
- R5: Command bit 31 set keeps chip select asserted into the next frame. When it is clear, chip select returns to its inactive level after the frame.
- R6: After a frame whose command bit 27 is set, status bit 28 becomes 1 and no further frame starts. Writing 1 to status bit 28 clears it and resumes the queue.
- R7: `irq` is 1 exactly while status bit 28 and interrupt-enable bit 28 are both 1.
- R8: During a frame, `cs_out` equals the inactive-level field (control bits 21:16) XOR the command's one-hot pattern (bits 21:16).
- R9: Each completed frame adds 1 to `frame_count`. A command with bit 26 set first zeroes the counter, so it reads 1 after that frame.
- R10: Control bit 11 flushes the pending commands and bit 10 flushes the receive FIFO. Both read back as 0.
- R11: A push while 4 commands are pending is dropped and sets status bit 1. A pop from an empty receive FIFO sets status bit 0. Both bits are sticky and clear on a write of 1.
- R12: Received frames are popped in arrival order, with up to 4 held.
- R13: With control bit 31 (engine enable) at 0, queued commands wait and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_push | input | 1 | Push strobe for the command queue |
| cmd_word | input | 32 | Command word |
| rx_pop | input | 1 | Pop strobe for the receive FIFO |
| rx_word | output | 32 | Head of the receive FIFO, data in bits 15:0 |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control register readback |
| attr_wr | input | 1 | Attribute set write strobe |
| attr_idx | input | 2 | Attribute set index |
| attr_wdata | input | 32 | Attribute write data |
| stat_wr | input | 1 | Status write-1-to-clear strobe |
| stat_wdata | input | 32 | Status clear mask |
| stat_rdata | output | 32 | Status word |
| ien_wr | input | 1 | Interrupt-enable write strobe |
| ien_wdata | input | 32 | Interrupt-enable data |
| irq | output | 1 | End-of-queue interrupt |
| frame_count | output | CNTW | Transfer counter |
| tick | input | 1 | SCK half-period pulse from the timing generator |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | NCS | Chip-select lines |

## Verification
The bench builds the block with its defaults: DEPTH=4, NCS=6 and CNTW=16. With these values, a fifth push already overflows the command queue, and four looped-back frames fill the receive FIFO, so both limits are reached with a handful of commands. `miso` is tied to `mosi`, and `tick` pulses every second clock, so even a 16-bit frame completes in about seventy cycles. This keeps the halt-and-resume, chip-select hold and flush scenarios short.

// File: rtl/cq_spi_master.sv
module cq_spi_master #(
  parameter int DEPTH = 4,
  parameter int NCS   = 6,
  parameter int CNTW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_push,
  input  logic [31:0]     cmd_word,
  input  logic            rx_pop,
  output logic [31:0]     rx_word,
  input  logic            ctl_wr,
  input  logic [31:0]     ctl_wdata,
  output logic [31:0]     ctl_rdata,
  input  logic            attr_wr,
  input  logic [1:0]      attr_idx,
  input  logic [31:0]     attr_wdata,
  input  logic            stat_wr,
  input  logic [31:0]     stat_wdata,
  output logic [31:0]     stat_rdata,
  input  logic            ien_wr,
  input  logic [31:0]     ien_wdata,
  output logic            irq,
  output logic [CNTW-1:0] frame_count,
  input  logic            tick,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic [NCS-1:0]  cs_out
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL} st_t;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  logic [31:0]    txq [DEPTH];
  logic [15:0]    rxq [DEPTH];
  logic [AW-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]  tx_cnt, rx_cnt;
  logic           master_en, ien, eoq_flg, ovf, udf;
  logic [NCS-1:0] inact, cs_pat;
  logic [6:0]     attr [4];
  st_t            st;
  logic [15:0]    tx_sr, rx_sr;
  logic [4:0]     h;
  logic [3:0]     fsz;
  logic           cpha, lsb, cont, eoq_c, ctc, cs_on, sck_r;

  wire [31:0] head      = txq[tx_rp];
  wire [6:0]  head_attr = attr[head[29:28]];
  wire tx_full    = tx_cnt == CW'(DEPTH);
  wire rx_full    = rx_cnt == CW'(DEPTH);
  wire push_ok    = cmd_push && !tx_full;
  wire pop_ok     = rx_pop && rx_cnt != '0;
  wire tx_clr     = ctl_wr && ctl_wdata[11];
  wire rx_clr     = ctl_wr && ctl_wdata[10];
  wire start      = st == S_IDLE && master_en && tx_cnt != '0 && !eoq_flg;
  wire sh_tick    = st == S_SHIFT && tick;
  wire sample     = sh_tick && (h[0] == cpha);
  wire shift_out  = sh_tick && (h[0] != cpha) && (h != '0);
  wire frame_done = sh_tick && (h == {fsz, 1'b1});
  wire rx_push    = frame_done && !rx_full;

  wire [15:0] rx_nx  = !sample ? rx_sr : (lsb ? {miso, rx_sr[15:1]} : {rx_sr[14:0], miso});
  wire [15:0] rx_val = lsb ? (rx_nx >> (4'd15 - fsz)) : rx_nx;

  assign rx_word    = {16'b0, rxq[rx_rp]};
  assign ctl_rdata  = {master_en, 31'b0} | (32'(inact) << 16);
  assign stat_rdata = {3'b0, eoq_flg, 26'b0, ovf, udf};
  assign irq        = eoq_flg & ien;
  assign sck        = sck_r;
  assign mosi       = lsb ? tx_sr[0] : tx_sr[15];
  assign cs_out     = inact ^ (cs_on ? cs_pat : '0);

  always_ff @(posedge clk)
    if (push_ok && !tx_clr) txq[tx_wp] <= cmd_word;

  always_ff @(posedge clk)
    if (rx_push && !rx_clr) rxq[rx_wp] <= rx_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (push_ok) tx_wp <= nxt(tx_wp);
      if (start)   tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(push_ok) - CW'(start);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (pop_ok)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(pop_ok);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      master_en <= 1'b0; inact <= '0; ien <= 1'b0;
      eoq_flg <= 1'b0; ovf <= 1'b0; udf <= 1'b0; frame_count <= '0;
      for (int i = 0; i < 4; i++) attr[i] <= '0;
    end else begin
      if (ctl_wr) begin
        master_en <= ctl_wdata[31];
        inact     <= ctl_wdata[16 +: NCS];
      end
      if (attr_wr) attr[attr_idx] <= attr_wdata[30:24];
      if (ien_wr)  ien <= ien_wdata[28];
      if (stat_wr) begin
        if (stat_wdata[28]) eoq_flg <= 1'b0;
        if (stat_wdata[1])  ovf <= 1'b0;
        if (stat_wdata[0])  udf <= 1'b0;
      end
      if (frame_done && eoq_c)  eoq_flg <= 1'b1;
      if (cmd_push && tx_full)  ovf <= 1'b1;
      if (rx_pop && rx_cnt == '0) udf <= 1'b1;
      if (frame_done) frame_count <= (ctc ? '0 : frame_count) + CNTW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cs_on <= 1'b0; sck_r <= 1'b0; h <= '0;
      tx_sr <= '0; rx_sr <= '0; fsz <= '0; cs_pat <= '0;
      cpha <= 1'b0; lsb <= 1'b0; cont <= 1'b0; eoq_c <= 1'b0; ctc <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          fsz    <= head_attr[6:3];
          sck_r  <= head_attr[2];
          cpha   <= head_attr[1];
          lsb    <= head_attr[0];
          cont   <= head[31];
          eoq_c  <= head[27];
          ctc    <= head[26];
          cs_pat <= head[16 +: NCS];
          tx_sr  <= head_attr[0] ? head[15:0] : (head[15:0] << (4'd15 - head_attr[6:3]));
          rx_sr  <= '0;
          h      <= '0;
          if (cs_on) st <= S_SHIFT;
          else begin
            cs_on <= 1'b1;
            st    <= S_LEAD;
          end
        end
        S_LEAD: if (tick) st <= S_SHIFT;
        S_SHIFT: if (tick) begin
          sck_r <= ~sck_r;
          h     <= h + 5'd1;
          rx_sr <= rx_nx;
          if (shift_out) tx_sr <= lsb ? (tx_sr >> 1) : (tx_sr << 1);
          if (frame_done) st <= cont ? S_IDLE : S_TRAIL;
        end
        S_TRAIL: if (tick) begin
          cs_on <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH)); // R11
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(DEPTH)); // R12
  AST_EOQ_HALT: assert property (@(posedge clk) disable iff (!rst_n) (eoq_flg && st == S_IDLE) |=> st == S_IDLE); // R6
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (frame_done && cont) |=> cs_on); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (frame_done && !ctc) |=> frame_count == $past(frame_count) + CNTW'(1)); // R9
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!master_en && st == S_IDLE) |=> st == S_IDLE); // R13
endmodule

// File: tb/cq_spi_master_tb.sv
module cq_spi_master_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cmd_push = 0, rx_pop = 0, ctl_wr = 0, attr_wr = 0, stat_wr = 0, ien_wr = 0;
  logic [31:0] cmd_word = '0, ctl_wdata = '0, attr_wdata = '0, stat_wdata = '0, ien_wdata = '0;
  logic [1:0]  attr_idx = '0;
  logic [31:0] rx_word, ctl_rdata, stat_rdata;
  logic irq, sck, mosi, miso;
  logic [15:0] frame_count;
  logic [5:0]  cs_out;

  int total = 0, bad = 0;
  logic [15:0] cap;
  int cap_n;
  logic [5:0] cap_cs;
  int rel;
  logic [5:0] cs_prev;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) tick <= ~tick;
  assign miso = mosi;

  cq_spi_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_word(cmd_word),
    .rx_pop(rx_pop), .rx_word(rx_word), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .attr_wr(attr_wr), .attr_idx(attr_idx), .attr_wdata(attr_wdata),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata), .irq(irq), .frame_count(frame_count),
    .tick(tick), .sck(sck), .mosi(mosi), .miso(miso), .cs_out(cs_out));

  always @(posedge sck) begin
    cap = {cap[14:0], mosi};
    cap_n++;
    cap_cs = cs_out;
  end

  always @(posedge clk) begin
    if (rst_n && cs_prev != 6'h3F && cs_out == 6'h3F) rel++;
    cs_prev = cs_out;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit c, input logic [1:0] s, input bit e,
                                     input bit t, input logic [5:0] p, input logic [15:0] d);
    return {c, 1'b0, s, e, t, 4'b0, p, d};
  endfunction

  function automatic logic [31:0] at(input logic [3:0] f, input bit pol, input bit pha, input bit l);
    return {1'b0, f, pol, pha, l, 24'b0};
  endfunction

  task automatic push(input logic [31:0] w);
    @(negedge clk); cmd_push = 1; cmd_word = w;
    @(negedge clk); cmd_push = 0;
  endtask

  task automatic wr_ctl(input logic [31:0] w);
    @(negedge clk); ctl_wr = 1; ctl_wdata = w;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wr_attr(input logic [1:0] i, input logic [31:0] w);
    @(negedge clk); attr_wr = 1; attr_idx = i; attr_wdata = w;
    @(negedge clk); attr_wr = 0;
  endtask

  task automatic wr_stat(input logic [31:0] w);
    @(negedge clk); stat_wr = 1; stat_wdata = w;
    @(negedge clk); stat_wr = 0;
  endtask

  task automatic wr_ien(input logic [31:0] w);
    @(negedge clk); ien_wr = 1; ien_wdata = w;
    @(negedge clk); ien_wr = 0;
  endtask

  task automatic pop_chk(input string req, input logic [15:0] exp);
    @(negedge clk);
    chk(req, rx_word, {16'b0, exp});
    rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic wait_cnt(input logic [15:0] target);
    int n = 0;
    while (frame_count !== target && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 cs", 32'(cs_out), 32'h0);
    chk("R1 sck", 32'(sck), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 status", stat_rdata, 32'h0);
    chk("R1 count", 32'(frame_count), 32'h0);
    chk("R1 ctl", ctl_rdata, 32'h0);
  endtask

  task automatic t_basic;
    wr_attr(2'd0, at(4'd7, 0, 0, 0));
    wr_ctl(32'h803F_0000);
    cap_n = 0;
    push(mk(0, 2'd0, 0, 1, 6'b000100, 16'hA5C3));
    wait_cnt(16'd1);
    chk("R3 msb order", 32'(cap[7:0]), 32'hC3);
    chk("R2 bit count", 32'(cap_n), 32'd8);
    chk("R8 cs pattern", 32'(cap_cs), 32'h3B);
    chk("R9 clear then count", 32'(frame_count), 32'd1);
    chk("R4 idle low", 32'(sck), 32'h0);
    chk("R5 released", 32'(cs_out), 32'h3F);
    pop_chk("R2 8-bit rx", 16'h00C3);
  endtask

  task automatic t_lsb;
    wr_attr(2'd3, at(4'd7, 0, 0, 1));
    cap_n = 0;
    push(mk(0, 2'd3, 0, 0, 6'b100000, 16'h12B1));
    wait_cnt(16'd2);
    chk("R3 lsb order", 32'(cap[7:0]), 32'h8D);
    chk("R8 cs pattern hi", 32'(cap_cs), 32'h1F);
    chk("R9 increment", 32'(frame_count), 32'd2);
    pop_chk("R2 lsb rx", 16'h00B1);
  endtask

  task automatic t_width;
    wr_attr(2'd1, at(4'd3, 0, 0, 0));
    wr_attr(2'd2, at(4'd15, 1, 1, 0));
    push(mk(0, 2'd1, 0, 0, 6'b000001, 16'hFFF6));
    push(mk(0, 2'd2, 0, 0, 6'b000001, 16'hBEEF));
    wait_cnt(16'd4);
    chk("R4 idle high", 32'(sck), 32'h1);
    pop_chk("R2 4-bit rx", 16'h0006);
    pop_chk("R12 16-bit rx order", 16'hBEEF);
  endtask

  task automatic t_cont;
    rel = 0;
    push(mk(1, 2'd0, 0, 0, 6'b000010, 16'h0011));
    push(mk(0, 2'd0, 0, 0, 6'b000010, 16'h0022));
    wait_cnt(16'd6);
    chk("R5 held releases", 32'(rel), 32'd1);
    rel = 0;
    push(mk(0, 2'd0, 0, 0, 6'b000010, 16'h0033));
    push(mk(0, 2'd0, 0, 0, 6'b000010, 16'h0044));
    wait_cnt(16'd8);
    chk("R5 separate releases", 32'(rel), 32'd2);
  endtask

  task automatic t_rxflush;
    wr_ctl(32'h803F_0400);
    chk("R10 clear bits read 0", ctl_rdata, 32'h803F_0000);
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
    @(negedge clk);
    chk("R11 underflow after rx flush", stat_rdata, 32'h0000_0001);
    wr_stat(32'h0000_0001);
    chk("R11 underflow cleared", stat_rdata, 32'h0);
  endtask

  task automatic t_eoq;
    wr_ien(32'h0);
    push(mk(0, 2'd0, 1, 1, 6'b000001, 16'h0055));
    push(mk(0, 2'd0, 0, 0, 6'b000001, 16'h0066));
    push(mk(0, 2'd0, 0, 0, 6'b000001, 16'h0077));
    wait_cnt(16'd1);
    repeat (150) @(negedge clk);
    chk("R6 queue halted", 32'(frame_count), 32'd1);
    chk("R6 flag set", stat_rdata, 32'h1000_0000);
    chk("R7 irq masked", 32'(irq), 32'h0);
    wr_ien(32'h1000_0000);
    chk("R7 irq enabled", 32'(irq), 32'h1);
    wr_stat(32'h1000_0000);
    chk("R7 irq after clear", 32'(irq), 32'h0);
    wait_cnt(16'd3);
    chk("R6 resumed", 32'(frame_count), 32'd3);
    pop_chk("R12 order 1", 16'h0055);
    pop_chk("R12 order 2", 16'h0066);
    pop_chk("R12 order 3", 16'h0077);
  endtask

  task automatic t_ovf;
    wr_ctl(32'h003F_0C00);
    for (int i = 0; i < 5; i++)
      push(mk(0, 2'd0, 0, i == 0, 6'b000001, 16'(8'h81 + i)));
    repeat (60) @(negedge clk);
    chk("R13 disabled no frames", 32'(frame_count), 32'd3);
    chk("R11 overflow flag", stat_rdata, 32'h0000_0002);
    wr_ctl(32'h803F_0000);
    wait_cnt(16'd4);
    repeat (100) @(negedge clk);
    chk("R11 fifth push dropped", 32'(frame_count), 32'd4);
    pop_chk("R12 ovf 1", 16'h0081);
    pop_chk("R12 ovf 2", 16'h0082);
    pop_chk("R12 ovf 3", 16'h0083);
    pop_chk("R12 ovf 4", 16'h0084);
    wr_stat(32'h0000_0002);
  endtask

  task automatic t_txflush;
    wr_ctl(32'h003F_0000);
    push(mk(0, 2'd0, 0, 1, 6'b000001, 16'h00A1));
    push(mk(0, 2'd0, 0, 0, 6'b000001, 16'h00A2));
    wr_ctl(32'h003F_0800);
    chk("R10 tx clear reads 0", ctl_rdata, 32'h003F_0000);
    wr_ctl(32'h803F_0000);
    repeat (200) @(negedge clk);
    chk("R10 flushed commands", 32'(frame_count), 32'd4);
    chk("R10 status clean", stat_rdata, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_lsb;
    t_width;
    t_cont;
    t_rxflush;
    t_eoq;
    t_ovf;
    t_txflush;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule